// File: doc/BRIEF.md
# Memory Protection Permission Checker

This block decides what a single memory access may do. Each cycle it takes a 32-bit address, an access type (read, write or execute) and a privilege flag, compares the address against a table of protection regions supplied on flat input buses, and registers the resulting read, write and execute permissions together with a region-hit flag, the index of the winning region and a fault flag. The region table is programmed elsewhere; this block only consumes it.

Two fixed rules sit on top of the table. The private peripheral window (address bits 31:20 equal to 0xE00) never consults the table and always takes the default permissions. Any address in the top eighth of the address space (bits 31:29 all ones) is never executable, whatever a region grants. When protection is switched off, the default permissions apply to every address. When no region matches, a privileged access may fall back to the default permissions if background access is allowed. Otherwise the access gets no permissions.

Internally the combinational decision selects one of three paths: PATH_DEFAULT, PATH_REGION or PATH_DENY. The selected path and the access type then fix the result, which is captured on the next rising clock edge. There is no other state.

Top module: `mpu_perm_chk`

## Requirements
- R1: When `mpu_en_i` is 0, every address gets the default permissions with `hit_o`=0. The default permissions are read=1 and write=1. Execute is 1 unless address bits 31:29 are 3'b111.
- R2: When address bits 31:20 equal 12'hE00, the default permissions apply with `hit_o`=0, even when protection is on and an enabled region covers the address.
- R3: Each region has a 6-bit size word. Bit 0 is the enable bit. Bits 5:1 hold a size code s, and the region covers 2^(s+1) bytes starting at its base. An address matches when its bits at and above position s+1 equal those of the base. A region whose enable bit is 0, or whose s is below 4, never matches.
- R4: When several enabled regions match, the one with the highest index wins, and `hit_o`=1 with `hit_rgn_o` giving that index. `hit_rgn_o` is 0 whenever `hit_o` is 0.
- R5: On a region hit, the region's 3-bit permission code sets read and write as follows, given as privileged/unprivileged. 000 gives none/none. 001 gives RW/none. 010 gives RW/R. 011 gives RW/RW. 100 gives none/none. 101 gives R/none. 110 and 111 give R/R.
- R6: On a region hit, execute is granted only if read is granted and the region's execute-never bit is 0.
- R7: An address with bits 31:29 equal to 3'b111 never gets execute permission, on any path.
- R8: With protection on, outside the peripheral window, and with no region matching: if `bg_allow_i`=1 and `priv_i`=1, the default permissions apply. Otherwise all three permissions are 0. In both cases `hit_o`=0.
- R9: `fault_o` is 1 exactly when the requested access is missing from the resulting permissions. Access codes: 0 is read, 1 is write, 2 is execute. Code 3 always faults.
- R10: All outputs are registered and appear one clock after the inputs. An active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mpu_en_i | input | 1 | Protection enable |
| bg_allow_i | input | 1 | Privileged accesses that miss all regions use the default permissions |
| addr_i | input | 32 | Access address |
| acc_type_i | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| priv_i | input | 1 | 1 for a privileged access |
| rgn_base_i | input | 32*NREG | Region base addresses, region i in bits [32i+31:32i] |
| rgn_size_i | input | 6*NREG | Region size words: bit 0 enable, bits 5:1 size code |
| rgn_ap_i | input | 3*NREG | Region permission codes |
| rgn_xn_i | input | NREG | Region execute-never bits |
| perm_r_o | output | 1 | Read permitted |
| perm_w_o | output | 1 | Write permitted |
| perm_x_o | output | 1 | Execute permitted |
| hit_o | output | 1 | A region decided the permissions |
| hit_rgn_o | output | $clog2(NREG) | Index of the winning region |
| fault_o | output | 1 | Requested access not permitted |

## Verification
Two rules can apply to the same access in one cycle, and the tests target both overlaps. The first overlap is the peripheral-window bypass together with a region hit. An enabled, fully permissive region is placed over the whole system space. The bench then checks that an access inside the window reports no hit and gets default permissions, while an access one megabyte higher reports the region. The second overlap is the system-space execute ban together with a region that grants execute. An execute request there must come back with execute cleared and a fault, while read and write still follow the region's code.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;
    localparam int AW      = 32;
    localparam int SZW     = 6;
    localparam int APW     = 3;
    localparam int MIN_SZ  = 4;
    localparam logic [11:0] PERIPH_TAG = 12'hE00;
    localparam logic [2:0]  SYS_TAG    = 3'b111;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PATH_DEFAULT = 2'd0,
        PATH_REGION  = 2'd1,
        PATH_DENY    = 2'd2
    } path_e;
endpackage

// File: rtl/mpu_rgn_match.sv
module mpu_rgn_match
    import mpu_chk_pkg::*;
(
    input  logic [AW-1:0]  addr_i,
    input  logic [AW-1:0]  base_i,
    input  logic [SZW-1:0] size_i,
    output logic           match_o
);
    logic [SZW-2:0] code;
    logic [AW-1:0]  keep_mask;

    always_comb begin
        code      = size_i[SZW-1:1];
        // clears the low code+1 bits; a code of 31 clears all of them
        keep_mask = {{(AW-1){1'b1}}, 1'b0} << code;
        match_o   = size_i[0] && (code >= (SZW-1)'(MIN_SZ)) &&
                    (((addr_i ^ base_i) & keep_mask) == '0);
    end
endmodule

// File: rtl/mpu_prio_pick.sv
module mpu_prio_pick #(
    parameter int NREG = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic [NREG-1:0] match_i,
    output logic            any_o,
    output logic [IDXW-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (match_i[i]) begin
                any_o = 1'b1;
                idx_o = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/mpu_ap_decode.sv
module mpu_ap_decode
    import mpu_chk_pkg::*;
(
    input  logic [APW-1:0] ap_i,
    input  logic           priv_i,
    output logic           rd_o,
    output logic           wr_o
);
    always_comb begin
        rd_o = 1'b0;
        wr_o = 1'b0;
        unique case (ap_i)
            3'b000: begin rd_o = 1'b0;   wr_o = 1'b0;   end
            3'b001: begin rd_o = priv_i; wr_o = priv_i; end
            3'b010: begin rd_o = 1'b1;   wr_o = priv_i; end
            3'b011: begin rd_o = 1'b1;   wr_o = 1'b1;   end
            3'b100: begin rd_o = 1'b0;   wr_o = 1'b0;   end
            3'b101: begin rd_o = priv_i; wr_o = 1'b0;   end
            3'b110,
            3'b111: begin rd_o = 1'b1;   wr_o = 1'b0;   end
            default: begin rd_o = 1'b0;  wr_o = 1'b0;   end
        endcase
    end
endmodule

// File: rtl/mpu_perm_chk.sv
module mpu_perm_chk
    import mpu_chk_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mpu_en_i,
    input  logic                 bg_allow_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [1:0]           acc_type_i,
    input  logic                 priv_i,
    input  logic [AW*NREG-1:0]   rgn_base_i,
    input  logic [SZW*NREG-1:0]  rgn_size_i,
    input  logic [APW*NREG-1:0]  rgn_ap_i,
    input  logic [NREG-1:0]      rgn_xn_i,
    output logic                 perm_r_o,
    output logic                 perm_w_o,
    output logic                 perm_x_o,
    output logic                 hit_o,
    output logic [IDXW-1:0]      hit_rgn_o,
    output logic                 fault_o
);
    logic [NREG-1:0] match;
    logic            any_match;
    logic [IDXW-1:0] win_idx;
    logic [APW-1:0]  win_ap;
    logic            win_xn;
    logic            ap_rd, ap_wr;
    logic            in_periph, in_sys;
    path_e           path;
    logic            nxt_r, nxt_w, nxt_x, nxt_hit, nxt_fault;
    logic [IDXW-1:0] nxt_idx;

    for (genvar g = 0; g < NREG; g++) begin : g_rgn
        mpu_rgn_match u_match (
            .addr_i  (addr_i),
            .base_i  (rgn_base_i[g*AW +: AW]),
            .size_i  (rgn_size_i[g*SZW +: SZW]),
            .match_o (match[g])
        );
    end

    mpu_prio_pick #(.NREG(NREG)) u_pick (
        .match_i (match),
        .any_o   (any_match),
        .idx_o   (win_idx)
    );

    assign win_ap = rgn_ap_i[win_idx*APW +: APW];
    assign win_xn = rgn_xn_i[win_idx];

    mpu_ap_decode u_ap (
        .ap_i   (win_ap),
        .priv_i (priv_i),
        .rd_o   (ap_rd),
        .wr_o   (ap_wr)
    );

    always_comb begin
        in_periph = (addr_i[AW-1:AW-12] == PERIPH_TAG);
        in_sys    = (addr_i[AW-1:AW-3] == SYS_TAG);
        if (!mpu_en_i || in_periph)      path = PATH_DEFAULT;
        else if (any_match)              path = PATH_REGION;
        else if (bg_allow_i && priv_i)   path = PATH_DEFAULT;
        else                             path = PATH_DENY;
    end

    always_comb begin
        nxt_r   = 1'b0;
        nxt_w   = 1'b0;
        nxt_x   = 1'b0;
        nxt_hit = 1'b0;
        nxt_idx = '0;
        unique case (path)
            PATH_DEFAULT: begin
                nxt_r = 1'b1;
                nxt_w = 1'b1;
                nxt_x = !in_sys;
            end
            PATH_REGION: begin
                nxt_r   = ap_rd;
                nxt_w   = ap_wr;
                nxt_x   = ap_rd && !win_xn && !in_sys;
                nxt_hit = 1'b1;
                nxt_idx = win_idx;
            end
            PATH_DENY: begin
                nxt_r = 1'b0;
            end
            default: begin
                nxt_r = 1'b0;
            end
        endcase
        unique case (acc_e'(acc_type_i))
            ACC_READ:  nxt_fault = !nxt_r;
            ACC_WRITE: nxt_fault = !nxt_w;
            ACC_EXEC:  nxt_fault = !nxt_x;
            ACC_RSVD:  nxt_fault = 1'b1;
            default:   nxt_fault = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perm_r_o  <= 1'b0;
            perm_w_o  <= 1'b0;
            perm_x_o  <= 1'b0;
            hit_o     <= 1'b0;
            hit_rgn_o <= '0;
            fault_o   <= 1'b0;
        end else begin
            perm_r_o  <= nxt_r;
            perm_w_o  <= nxt_w;
            perm_x_o  <= nxt_x;
            hit_o     <= nxt_hit;
            hit_rgn_o <= nxt_idx;
            fault_o   <= nxt_fault;
        end
    end
endmodule

// File: rtl/mpu_perm_chk_sva.sv
module mpu_perm_chk_sva #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mpu_en_i,
    input logic [31:0]     addr_i,
    input logic [1:0]      acc_type_i,
    input logic            perm_r_o,
    input logic            perm_w_o,
    input logic            perm_x_o,
    input logic            hit_o,
    input logic [IDXW-1:0] hit_rgn_o,
    input logic            fault_o
);
    AST_OFF_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !mpu_en_i |=> (!hit_o && perm_r_o && perm_w_o)); // R1
    AST_PERIPH_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i[31:20] == 12'hE00) |=> (!hit_o && perm_r_o && perm_w_o && !perm_x_o)); // R2
    AST_NOHIT_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (hit_rgn_o == '0)); // R4
    AST_SYS_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i[31:29] == 3'b111) |=> !perm_x_o); // R7
    AST_READ_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type_i == 2'd0) |=> (fault_o != perm_r_o)); // R9
    AST_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type_i == 2'd1) |=> (fault_o != perm_w_o)); // R9
    AST_EXEC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type_i == 2'd2) |=> (fault_o != perm_x_o)); // R9
    AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type_i == 2'd3) |=> fault_o); // R9
endmodule

bind mpu_perm_chk mpu_perm_chk_sva #(.IDXW(IDXW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .mpu_en_i   (mpu_en_i),
    .addr_i     (addr_i),
    .acc_type_i (acc_type_i),
    .perm_r_o   (perm_r_o),
    .perm_w_o   (perm_w_o),
    .perm_x_o   (perm_x_o),
    .hit_o      (hit_o),
    .hit_rgn_o  (hit_rgn_o),
    .fault_o    (fault_o)
);

// File: tb/tb_mpu_perm_chk.sv
module tb_mpu_perm_chk;
    localparam int NREG = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                mpu_en = 1'b0;
    logic                bg_allow = 1'b0;
    logic [31:0]         addr = '0;
    logic [1:0]          acc = '0;
    logic                priv = 1'b0;
    logic [32*NREG-1:0]  rgn_base = '0;
    logic [6*NREG-1:0]   rgn_size = '0;
    logic [3*NREG-1:0]   rgn_ap = '0;
    logic [NREG-1:0]     rgn_xn = '0;
    logic                perm_r, perm_w, perm_x, hit, fault;
    logic [2:0]          hit_rgn;
    int                  total = 0;
    int                  bad = 0;

    always #2 clk = ~clk;

    mpu_perm_chk #(.NREG(NREG)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mpu_en_i   (mpu_en),
        .bg_allow_i (bg_allow),
        .addr_i     (addr),
        .acc_type_i (acc),
        .priv_i     (priv),
        .rgn_base_i (rgn_base),
        .rgn_size_i (rgn_size),
        .rgn_ap_i   (rgn_ap),
        .rgn_xn_i   (rgn_xn),
        .perm_r_o   (perm_r),
        .perm_w_o   (perm_w),
        .perm_x_o   (perm_x),
        .hit_o      (hit),
        .hit_rgn_o  (hit_rgn),
        .fault_o    (fault)
    );

    // expected byte: {r, w, x, hit, idx[2:0], fault}
    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  acc;
        logic        priv;
        logic        en;
        logic        bg;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t VEC [NVEC] = '{
        '{32'h2000_0100, 2'd0, 1'b0, 1'b1, 1'b0, 8'b1111_0000, 8'd3},  // R3 in region 0
        '{32'h2000_8010, 2'd1, 1'b1, 1'b1, 1'b0, 8'b1001_0011, 8'd4},  // R4 region 1 over region 0
        '{32'h2000_8010, 2'd2, 1'b1, 1'b1, 1'b0, 8'b1001_0011, 8'd6},  // R6 XN set
        '{32'h0000_0040, 2'd0, 1'b0, 1'b1, 1'b0, 8'b0001_0111, 8'd5},  // R5 code 001 unpriv
        '{32'h0000_0040, 2'd1, 1'b1, 1'b1, 1'b0, 8'b1111_0110, 8'd5},  // R5 code 001 priv
        '{32'hE000_E100, 2'd2, 1'b1, 1'b1, 1'b0, 8'b1100_0001, 8'd2},  // R2 window exec
        '{32'hE000_E100, 2'd0, 1'b0, 1'b1, 1'b0, 8'b1100_0000, 8'd2},  // R2 window read
        '{32'hE010_0000, 2'd2, 1'b1, 1'b1, 1'b0, 8'b1101_0101, 8'd7},  // R7 region grants, sys bans
        '{32'h1000_0004, 2'd0, 1'b1, 1'b1, 1'b0, 8'b0000_0001, 8'd3},  // R3 too-small region
        '{32'h1000_0004, 2'd0, 1'b1, 1'b1, 1'b1, 8'b1110_0000, 8'd8},  // R8 background priv
        '{32'h1000_0004, 2'd0, 1'b0, 1'b1, 1'b1, 8'b0000_0001, 8'd8},  // R8 background unpriv
        '{32'h4000_0010, 2'd0, 1'b1, 1'b1, 1'b0, 8'b0000_0001, 8'd3},  // R3 disabled region
        '{32'h5000_0010, 2'd1, 1'b1, 1'b1, 1'b0, 8'b1011_1101, 8'd5},  // R5 code 101 priv write
        '{32'h5000_0010, 2'd0, 1'b0, 1'b1, 1'b0, 8'b0001_1101, 8'd5},  // R5 code 101 unpriv
        '{32'h6000_0000, 2'd0, 1'b1, 1'b1, 1'b0, 8'b0001_1111, 8'd5},  // R5 code 000
        '{32'h6000_0000, 2'd2, 1'b0, 1'b0, 1'b0, 8'b1110_0000, 8'd1},  // R1 off
        '{32'hF000_0000, 2'd2, 1'b1, 1'b0, 1'b0, 8'b1100_0001, 8'd1},  // R1 off, sys
        '{32'h2000_0100, 2'd3, 1'b1, 1'b1, 1'b0, 8'b1111_0001, 8'd9},  // R9 reserved code
        '{32'h2000_0100, 2'd1, 1'b0, 1'b1, 1'b0, 8'b1111_0000, 8'd9},  // R9 write ok
        '{32'h2000_7FFC, 2'd2, 1'b0, 1'b1, 1'b0, 8'b1111_0000, 8'd4},  // R4 just below region 1
        '{32'h2010_0000, 2'd0, 1'b1, 1'b1, 1'b0, 8'b0000_0001, 8'd3},  // R3 just past region 0
        '{32'h2000_8000, 2'd0, 1'b0, 1'b1, 1'b0, 8'b1001_0010, 8'd6},  // R6 read, no exec
        '{32'hE00F_FFFF, 2'd0, 1'b0, 1'b1, 1'b0, 8'b1100_0000, 8'd2}   // R2 window top
    };

    task automatic set_rgn(input int i, input logic [31:0] base, input int s,
                           input logic en, input logic [2:0] ap, input logic xn);
        rgn_base[i*32 +: 32] = base;
        rgn_size[i*6 +: 6]   = {s[4:0], en};
        rgn_ap[i*3 +: 3]     = ap;
        rgn_xn[i]            = xn;
    endtask

    task automatic check(input logic [7:0] exp, input int req, input int tag);
        logic [7:0] got;
        got = {perm_r, perm_w, perm_x, hit, hit_rgn, fault};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d case %0d: got rwxh_idx_f=%b expected %b", req, tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [1:0] t, input logic p,
                         input logic en, input logic bg);
        @(negedge clk);
        addr = a; acc = t; priv = p; mpu_en = en; bg_allow = bg;
        @(posedge clk);
        #1;
    endtask

    initial begin
        set_rgn(0, 32'h2000_0000, 19, 1'b1, 3'b011, 1'b0);
        set_rgn(1, 32'h2000_8000, 14, 1'b1, 3'b110, 1'b1);
        set_rgn(2, 32'hE000_0000, 28, 1'b1, 3'b011, 1'b0);
        set_rgn(3, 32'h0000_0000, 15, 1'b1, 3'b001, 1'b0);
        set_rgn(4, 32'h1000_0000,  3, 1'b1, 3'b011, 1'b0);
        set_rgn(5, 32'h4000_0000, 11, 1'b0, 3'b011, 1'b0);
        set_rgn(6, 32'h5000_0000, 11, 1'b1, 3'b101, 1'b0);
        set_rgn(7, 32'h6000_0000, 11, 1'b1, 3'b000, 1'b0);
        addr = 32'h2000_0100; mpu_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(8'b0000_0000, 10, 100);  // R10 reset holds outputs at 0
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            apply(VEC[k].addr, VEC[k].acc, VEC[k].priv, VEC[k].en, VEC[k].bg);
            check(VEC[k].exp, int'(VEC[k].req), k);
        end

        // R10 one-cycle latency: new inputs do not show before the edge
        apply(32'h0000_0040, 2'd0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        addr = 32'h2000_0100; acc = 2'd0; priv = 1'b0;
        #1;
        check(8'b0001_0111, 10, 101);
        @(posedge clk);
        #1;
        check(8'b1111_0000, 10, 102);

        // R5 reserved code 100 and code 111
        set_rgn(7, 32'h6000_0000, 11, 1'b1, 3'b100, 1'b0);
        apply(32'h6000_0000, 2'd0, 1'b1, 1'b1, 1'b0);
        check(8'b0001_1111, 5, 103);
        set_rgn(7, 32'h6000_0000, 11, 1'b1, 3'b111, 1'b0);
        apply(32'h6000_0000, 2'd0, 1'b0, 1'b1, 1'b0);
        check(8'b1011_1110, 5, 104);
        apply(32'h6000_0000, 2'd1, 1'b1, 1'b1, 1'b0);
        check(8'b1011_1111, 5, 105);

        // R3 full-space region (code 31) wins as highest index (R4)
        set_rgn(7, 32'h9000_0000, 31, 1'b1, 3'b011, 1'b0);
        apply(32'h8000_0000, 2'd0, 1'b0, 1'b1, 1'b0);
        check(8'b1111_1110, 3, 106);
        apply(32'h2000_8010, 2'd2, 1'b0, 1'b1, 1'b0);
        check(8'b1111_1110, 4, 107);
        // R2 window still bypasses a region that covers everything
        apply(32'hE000_0000, 2'd2, 1'b1, 1'b1, 1'b0);
        check(8'b1100_0001, 2, 108);
        // R7 region grants execute, system space removes it
        apply(32'hF000_0000, 2'd2, 1'b0, 1'b1, 1'b0);
        check(8'b1101_1111, 7, 109);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule